// File: doc/BRIEF.md
# Three-Lane Seven-to-One Link Serializer

This block turns a 21-bit parallel word into three serial data lanes and one forwarded framing clock lane. The word is taken on every rising edge of a word clock. It is then sent out over the next word period as seven bit slots per lane. The serial side runs on a bit-rate clock that is supplied from outside at seven times the word rate, so the block contains no PLL. The word clock arrives as a plain input and its edges are detected in the bit clock domain.

Each output is single-ended. A separate output-enable flag stands for the high-impedance state of a real differential driver. An active-low powerdown input disables every output at once. When powerdown is released, a lock counter keeps the outputs disabled for a set number of word clocks, which models the settling time of a PLL. After that the outputs start, always on a word boundary.

Top module: `lane7_serializer`

## Requirements
- R1: A rising edge of `word_clk` (low at one bit clock edge, high at the next) captures all 21 bits of `din` together as one word.
- R2: Lane k carries `din` bits 7k to 7k+6, lowest-numbered bit first. Slot n of lane k holds bit 7k+n.
- R3: Each bit lasts exactly one bit clock. Slot 0 appears in the bit clock that starts with the word clock rise, and slot n appears n bit clocks later.
- R4: While enabled, `fclk_o` sends the slot pattern 1,1,1,1,0,0,0 in every word period, high for slots 0 to 3 and low for slots 4 to 6.
- R5: The word captured at one word clock rise is sent during the period that begins at the next rise. Changes to `din` between rises do not affect the word being sent.
- R6: When `pwr_n` is low, `oe_o` is 0 in that same cycle, without waiting for a clock edge.
- R7: After reset or after `pwr_n` goes high, `oe_o` stays 0 until the LOCK_WORDS-th word clock rise seen with `pwr_n` high. From that rise onwards `oe_o` is 1.
- R8: Whenever `oe_o` is 0, `lane_o` and `fclk_o` are held at 0.
- R9: Spare input bits that are tied to 0 arrive as 0 in their slots.
- R10: During reset `oe_o`, `fclk_o` and `lane_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit-rate clock, seven times the word rate |
| rst_n | input | 1 | Active-low synchronous reset |
| word_clk | input | 1 | Word clock; a rising edge captures `din` |
| pwr_n | input | 1 | Active-low powerdown |
| din | input | 21 | Parallel input word |
| lane_o | output | 3 | Serial data lanes, one bit per lane |
| fclk_o | output | 1 | Forwarded framing clock lane |
| oe_o | output | 1 | Output enable; 0 stands for high impedance |

## Verification
The bench builds the block with three lanes of seven slots, a clock-high span of four slots, and LOCK_WORDS set to 4. The short lock interval allows the full disabled window, the rise at which the outputs turn on, and a second lock after a powerdown to all be checked slot by slot within a few dozen words. The bench changes `din` in the middle of each period. This shows that the double buffer keeps each word intact until the next rise.

// File: rtl/lane7_serializer.sv
module lane7_serializer #(
  parameter int LANES      = 3,
  parameter int SLOTS      = 7,
  parameter int CLK_HI     = 4,
  parameter int LOCK_WORDS = 1024
) (
  input  logic                     bit_clk,
  input  logic                     rst_n,
  input  logic                     word_clk,
  input  logic                     pwr_n,
  input  logic [LANES*SLOTS-1:0]   din,
  output logic [LANES-1:0]         lane_o,
  output logic                     fclk_o,
  output logic                     oe_o
);
  localparam int W  = LANES * SLOTS;
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int LW = $clog2(LOCK_WORDS + 1);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic          wclk_q;
  logic [W-1:0]  hold_q;
  logic [W-1:0]  shreg_q;
  logic [SW-1:0] slot_q;
  logic [LW-1:0] lock_q;
  logic [LANES-1:0] lane_bit;
  logic rise, locked;

  assign rise   = word_clk & ~wclk_q;
  assign locked = (lock_q == LW'(LOCK_WORDS));
  assign oe_o   = locked & pwr_n;
  assign fclk_o = oe_o & (slot_q < SW'(CLK_HI));
  assign lane_o = oe_o ? lane_bit : '0;

  always_ff @(posedge bit_clk) begin
    if (!rst_n) begin
      wclk_q <= 1'b0;
      hold_q <= '0;
      slot_q <= LAST;
    end else begin
      wclk_q <= word_clk;
      if (rise) begin
        hold_q <= din;
        slot_q <= '0;
      end else if (slot_q != LAST) begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge bit_clk) begin
    if (!rst_n)
      lock_q <= '0;
    else if (!pwr_n)
      lock_q <= '0;
    else if (rise && !locked)
      lock_q <= lock_q + 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge bit_clk) begin
      if (!rst_n)
        shreg_q[g*SLOTS +: SLOTS] <= '0;
      else if (rise)
        shreg_q[g*SLOTS +: SLOTS] <= hold_q[g*SLOTS +: SLOTS];
      else
        shreg_q[g*SLOTS +: SLOTS] <= {1'b0, shreg_q[g*SLOTS+1 +: SLOTS-1]};
    end
    assign lane_bit[g] = shreg_q[g*SLOTS];
  end
endmodule

module lane7_serializer_chk #(
  parameter int LANES = 3,
  parameter int SW    = 3,
  parameter int SLOTS = 7
) (
  input logic             bit_clk,
  input logic             rst_n,
  input logic             pwr_n,
  input logic             oe_o,
  input logic             fclk_o,
  input logic [LANES-1:0] lane_o,
  input logic [SW-1:0]    slot_q
);
  a_r6_pd_disables: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !pwr_n |-> !oe_o);
  a_r8_quiet_when_off: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !oe_o |-> (lane_o == '0 && !fclk_o));
  a_r7_start_on_boundary: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(oe_o) |-> (fclk_o && slot_q == '0));
  a_r7_needs_power: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(oe_o) |-> $past(pwr_n));
  a_r3_slot_range: assert property (@(posedge bit_clk) disable iff (!rst_n)
    slot_q <= SW'(SLOTS - 1));
endmodule

bind lane7_serializer lane7_serializer_chk #(.LANES(LANES), .SW(SW), .SLOTS(SLOTS)) u_chk (
  .bit_clk(bit_clk), .rst_n(rst_n), .pwr_n(pwr_n), .oe_o(oe_o),
  .fclk_o(fclk_o), .lane_o(lane_o), .slot_q(slot_q)
);

// File: tb/lane7_serializer_test.sv
module lane7_serializer_test;
  localparam int L     = 4;
  localparam int LANES = 3;
  localparam int SLOTS = 7;
  localparam int W     = LANES * SLOTS;

  logic bit_clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_clk = 1'b0;
  logic pwr_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [LANES-1:0] lane_o;
  logic fclk_o, oe_o;

  int total = 0, bad = 0, r = 0, pushes = 0, frames = 0;
  bit done = 0;
  logic [W-1:0] exp_q[$];

  lane7_serializer #(.LANES(LANES), .SLOTS(SLOTS), .CLK_HI(4), .LOCK_WORDS(L)) uut (
    .bit_clk(bit_clk), .rst_n(rst_n), .word_clk(word_clk), .pwr_n(pwr_n),
    .din(din), .lane_o(lane_o), .fclk_o(fclk_o), .oe_o(oe_o));

  always #5 bit_clk = ~bit_clk;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic send_word(input logic [W-1:0] w, input bit push_ok);
    @(negedge bit_clk);
    r++;
    word_clk = 1'b1;
    din = w;
    if (push_ok && pwr_n && r >= L - 1) begin
      exp_q.push_back(w);
      pushes++;
    end
    for (int i = 1; i < SLOTS; i++) begin
      @(negedge bit_clk);
      chk(oe_o == (pwr_n && r >= L), "R7 oe", W'(oe_o), W'(pwr_n && r >= L));
      if (i == 2) din = ~w;          // R5: mid-period change must not leak
      if (i == 4) word_clk = 1'b0;
    end
  endtask

  initial begin : monitor
    logic prev = 1'b0;
    logic [W-1:0] got, e;
    logic [SLOTS-1:0] fpat;
    forever begin
      @(negedge bit_clk);
      if (oe_o && fclk_o && !prev) begin
        got = '0;
        fpat = '0;
        for (int k = 0; k < SLOTS; k++) begin
          if (k > 0) @(negedge bit_clk);
          for (int l = 0; l < LANES; l++) got[l*SLOTS+k] = lane_o[l];
          fpat[k] = fclk_o;
        end
        prev = fpat[SLOTS-1];
        frames++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected frame", got, '0);
        end else begin
          e = exp_q.pop_front();
          chk(got == e, "R1 R2 R3 word", got, e);
          if (e[W-1:W-3] == 3'b000)
            chk(got[W-1:W-3] == 3'b000, "R9 spare", got, e);
        end
        chk(fpat == 7'b0001111, "R4 frame clock", W'(fpat), W'(7'b0001111));
      end else begin
        prev = fclk_o;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge bit_clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 1'b0, 1'b1);
      summary();
    end
  end

  function automatic logic [W-1:0] pattern(input int n);
    case (n % 6)
      0: return '0;
      1: return {W{1'b1}};
      2: return 21'h0AAAAA;
      3: return 21'h155555 & 21'h03FFFF;
      4: return W'(1) << (n % W);
      default: return W'($urandom) & 21'h03FFFF;
    endcase
  endfunction

  initial begin : main
    repeat (3) @(negedge bit_clk);
    chk(oe_o == 1'b0, "R10 oe", W'(oe_o), '0);
    chk(fclk_o == 1'b0, "R10 fclk", W'(fclk_o), '0);
    chk(lane_o == '0, "R10 lanes", W'(lane_o), '0);
    rst_n = 1'b1;
    r = 0;

    for (int n = 0; n < L + 8; n++) send_word(pattern(n), 1'b1);
    send_word(21'h1F0F0F, 1'b0);
    repeat (10) @(negedge bit_clk);
    chk(exp_q.size() == 0, "R5 drain A", W'(exp_q.size()), '0);
    chk(oe_o == 1'b1, "R7 stays on", W'(oe_o), W'(1));

    @(negedge bit_clk);
    pwr_n = 1'b0;
    #1;
    chk(oe_o == 1'b0, "R6 immediate off", W'(oe_o), '0);
    chk(fclk_o == 1'b0, "R8 fclk low", W'(fclk_o), '0);
    chk(lane_o == '0, "R8 lanes low", W'(lane_o), '0);
    send_word({W{1'b1}}, 1'b0);
    send_word(21'h123456, 1'b0);
    chk(lane_o == '0, "R8 lanes low in pd", W'(lane_o), '0);

    @(negedge bit_clk);
    pwr_n = 1'b1;
    r = 0;
    for (int n = 0; n < L + 6; n++) send_word(pattern(n + 3) ^ W'(n), 1'b1);
    send_word('0, 1'b0);
    repeat (10) @(negedge bit_clk);
    chk(exp_q.size() == 0, "R5 drain B", W'(exp_q.size()), '0);
    chk(frames == pushes, "R7 frame count", W'(frames), W'(pushes));

    done = 1;
    summary();
  end
endmodule